// File: doc/BRIEF.md
# Shared-Pin Delta-Sigma ADC Reader

This block is a synchronous controller for a 24-bit delta-sigma converter that reports "data ready" and its serial result on one shared input line. On a start request it forces the converter into reset by holding the serial clock high for several whole conversion frames. It then drops the clock and follows the converter's frame rhythm from the edges of the shared line. A frame opens with a rising edge. The line then falls to announce that a result is ready. After a guard delay the controller issues 24 serial clock pulses and assembles the result most significant bit first.

Each finished word appears on a 24-bit data bus with a one-cycle valid strobe. A settled flag accompanies each word and stays low for the words the converter's digital filter produces before it has settled. A watchdog abandons a frame whose ready indication never arrives. The controller then waits for the next frame boundary, so a stray falling edge cannot start a read out of step. All converter timing is given in converter master-clock periods, each converted to system clock cycles by one parameter.

Top module: `sdadc_reader`

## Requirements
- R1: One cycle after `start_i` is sampled high, `busy_o` and `sclk_o` go high together. Both stay high for exactly RESET_FRAMES×FRAME_MCLK×MCLK_DIV cycles (3072 with the default values), then both go low.
- R2: Outside reset, `sclk_o` idles low. It is high only for read pulses of exactly SCLK_HALF cycles, and it is low after reset with no start.
- R3: A read begins only after a rising edge and then a falling edge on `line_i`. The first `sclk_o` rise comes no sooner than SETTLE_MCLK×MCLK_DIV cycles after the falling edge reaches `line_i`.
- R4: Each read makes 24 `sclk_o` pulses. The bit shown on `line_i` after pulse k is sampled at the end of that pulse's high phase and becomes bit 23−k of the word (bit 23 first). `data_o` then carries the word while `valid_o` is high for exactly one cycle.
- R5: After each reset, the first DISCARD (5) words are delivered with `settled_o` low. From the sixth word onward, `settled_o` is high with each word.
- R6: If no falling edge follows a rising edge within WD_FRAMES×FRAME_MCLK×MCLK_DIV cycles (1536 by default), that frame is abandoned. A later falling edge with no new rising edge before it produces no word.
- R7: A start request while words are being read restarts the reset sequence, clears `settled_o` at once, and restarts the count of discarded words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the converter reset sequence |
| line_i | input | 1 | Shared ready/data line from the converter (asynchronous) |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | High while the converter is held in reset |
| valid_o | output | 1 | One-cycle strobe for a new word |
| data_o | output | 24 | Most recent word |
| settled_o | output | 1 | The word on `data_o` comes after the filter has settled |

## Verification
A controller out of step with the frame shows up on the data bus within one frame as a word that is bit-shifted or out of place, or as a word that should not exist. A wrong hold count shows up at once in the measured length of the reset pulse. A lost or miscounted settle counter shows up on the sixth word after a reset, where `settled_o` takes the wrong value. A missing watchdog shows up as an extra word in the frame whose ready phase is stretched. A guard delay that is too short shows up in the measured gap between the falling edge and the first clock pulse.

// File: rtl/sdadc_reader.sv
module sdadc_reader #(
  parameter int WORD_W       = 24,
  parameter int MCLK_DIV     = 2,
  parameter int SCLK_HALF    = 4,
  parameter int FRAME_MCLK   = 384,
  parameter int RESET_FRAMES = 4,
  parameter int SETTLE_MCLK  = 6,
  parameter int DISCARD      = 5,
  parameter int WD_FRAMES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              line_i,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              settled_o
);
  localparam int RST_CYC = RESET_FRAMES * FRAME_MCLK * MCLK_DIV;
  localparam int WD_CYC  = WD_FRAMES * FRAME_MCLK * MCLK_DIV;
  localparam int DLY_CYC = SETTLE_MCLK * MCLK_DIV;
  localparam int MAXC    = (RST_CYC > WD_CYC) ? RST_CYC : WD_CYC;
  localparam int CW      = $clog2(MAXC + 1);
  localparam int BW      = $clog2(WORD_W + 1);
  localparam int NW      = $clog2(DISCARD + 2);

  typedef enum logic [2:0] {S_IDLE, S_RESET, S_RISE, S_FALL, S_DELAY, S_SHIFT} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bits;
  logic [NW-1:0]     nwords;
  logic              hi;
  logic [2:0]        sy;
  logic [WORD_W-1:0] shreg;

  wire rise = sy[1] & ~sy[2];
  wire fall = ~sy[1] & sy[2];

  assign busy_o = (state == S_RESET);
  assign sclk_o = busy_o | ((state == S_SHIFT) & hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bits <= '0; nwords <= '0; hi <= 1'b0;
      shreg <= '0; data_o <= '0; valid_o <= 1'b0; settled_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        state <= S_RESET; cnt <= '0; nwords <= '0; settled_o <= 1'b0; hi <= 1'b0;
      end else begin
        case (state)
          S_RESET:
            if (cnt == CW'(RST_CYC - 1)) begin state <= S_RISE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          S_RISE:
            if (rise) begin state <= S_FALL; cnt <= '0; end
          S_FALL:
            if (fall) begin state <= S_DELAY; cnt <= '0; end
            else if (cnt == CW'(WD_CYC - 1)) begin state <= S_RISE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          S_DELAY:
            if (cnt == CW'(DLY_CYC - 1)) begin
              state <= S_SHIFT; cnt <= '0; hi <= 1'b1; bits <= '0;
            end else cnt <= cnt + 1'b1;
          S_SHIFT:
            if (cnt == CW'(SCLK_HALF - 1)) begin
              cnt <= '0;
              if (hi) begin
                shreg <= {shreg[WORD_W-2:0], sy[1]};
                bits  <= bits + 1'b1;
                hi    <= 1'b0;
              end else if (bits == BW'(WORD_W)) begin
                data_o    <= shreg;
                valid_o   <= 1'b1;
                settled_o <= (nwords >= NW'(DISCARD));
                if (nwords <= NW'(DISCARD)) nwords <= nwords + 1'b1;
                state <= S_RISE;
              end else hi <= 1'b1;
            end else cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  logic [CW-1:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= (sclk_o && !busy_o) ? run + 1'b1 : '0;
  end

  a_r1_hold_is_high: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> sclk_o);
  a_r1_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !start_i) |-> !sclk_o);
  a_r2_short_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    run <= CW'(SCLK_HALF));
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r5_settle_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled_o) |-> valid_o);
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && !settled_o));
endmodule

// File: tb/tb_sdadc_reader.sv
`timescale 1ns/1ps
module tb_sdadc_reader;
  localparam int W = 24, MD = 2, HALF = 4, FRAME = 384, RSTF = 4, SETTLE = 6, DISC = 5, WDF = 2;
  localparam int READY_MCLK = 36;
  localparam int RST_CYC = RSTF * FRAME * MD;
  localparam int DLY_CYC = SETTLE * MD;
  localparam int READY_LEN = READY_MCLK * MD;
  localparam int DATA_LEN = (FRAME - READY_MCLK) * MD;
  localparam int LONG_READY = 3 * FRAME * MD;

  logic clk = 0, rst_n = 0, start = 0, line = 0;
  logic sclk, busy, valid, settled;
  logic [W-1:0] data;

  sdadc_reader #(.WORD_W(W), .MCLK_DIV(MD), .SCLK_HALF(HALF), .FRAME_MCLK(FRAME),
    .RESET_FRAMES(RSTF), .SETTLE_MCLK(SETTLE), .DISCARD(DISC), .WD_FRAMES(WDF)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_i(line), .sclk_o(sclk),
    .busy_o(busy), .valid_o(valid), .data_o(data), .settled_o(settled));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_settled(int idx);
    return idx >= DISC;
  endfunction

  logic [W-1:0] directed [4] = '{24'hFFFFFF, 24'h000000, 24'h800001, 24'h555555};
  int dir_idx = 0;
  function automatic logic [W-1:0] pick_word();
    logic [W-1:0] w;
    if (dir_idx < 4) begin w = directed[dir_idx]; dir_idx++; end
    else w = W'($urandom);
    return w;
  endfunction

  bit gen_on = 0, long_next = 0, long_cur = 0, long_done = 0;
  int cyc = 0, pos = 0, frame_len = 0, ready_len = 0, bitidx = W, fall_cyc = 0;
  int wcount = 0, words_in_frame = 0, run = 0, max_run = 0;
  logic sclk_q = 0;
  logic [W-1:0] cur = '0;

  always @(negedge clk) begin
    cyc++;
    if (valid) begin
      check(data == cur, "R4 word", data, cur);
      check(settled == exp_settled(wcount), "R5 settled", settled, exp_settled(wcount));
      wcount++;
      words_in_frame++;
    end
    if (sclk && !busy) begin run++; if (run > max_run) max_run = run; end
    else run = 0;
    if (!gen_on) begin
      line = 0; pos = 0; bitidx = W;
    end else begin
      if (pos == 0) begin
        line = 1; cur = pick_word(); words_in_frame = 0;
        long_cur = long_next; long_next = 0;
        ready_len = long_cur ? LONG_READY : READY_LEN;
        frame_len = ready_len + DATA_LEN;
      end else if (pos == ready_len) begin
        line = 0; bitidx = 0; fall_cyc = cyc;
      end
      if (sclk && !sclk_q) begin
        if (bitidx == 0)
          check((cyc - fall_cyc) >= DLY_CYC && (cyc - fall_cyc) <= DLY_CYC + 6,
                "R3 guard delay", cyc - fall_cyc, DLY_CYC);
        if (bitidx < W) begin line = cur[W-1-bitidx]; bitidx++; end
      end else if (!sclk && sclk_q && bitidx == W) line = 0;
      pos++;
      if (pos == frame_len) begin
        if (long_cur) begin
          check(words_in_frame == 0, "R6 abandoned frame", words_in_frame, 0);
          long_done = 1;
        end
        pos = 0;
      end
    end
    sclk_q = sclk;
  end

  task automatic do_reset_seq();
    int n = 0, low_seen = 0;
    @(negedge clk); gen_on = 0; start = 1;
    @(negedge clk); start = 0;
    check(settled == 0, "R7 settled cleared", settled, 0);
    wcount = 0;
    while (busy) begin
      n++;
      if (!sclk) low_seen++;
      @(negedge clk);
    end
    check(n == RST_CYC, "R1 hold length", n, RST_CYC);
    check(low_seen == 0, "R1 clock high in hold", low_seen, 0);
    check(sclk == 0, "R1 clock low after hold", sclk, 0);
    repeat ($urandom_range(50, 5)) @(negedge clk);
    check(sclk == 0 && valid == 0, "R2 idle before frames", {sclk, valid}, 0);
    gen_on = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(sclk == 0 && busy == 0 && valid == 0 && settled == 0, "R2 reset state",
              {sclk, busy, valid, settled}, 0);
        repeat (30) @(negedge clk);
        check(sclk == 0 && valid == 0, "R2 idle without start", {sclk, valid}, 0);
        do_reset_seq();
        wait (wcount == 7);
        long_next = 1;
        wait (long_done);
        wait (wcount == 10);
        repeat ($urandom_range(300, 20)) @(negedge clk);
        do_reset_seq();
        wait (wcount == 7);
        repeat (10) @(negedge clk);
        check(max_run == HALF, "R2 pulse width", max_run, HALF);
      end
      begin
        repeat (150000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired wcount=%0d expected progress", wcount);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule